// File: doc/BRIEF.md
# Direct-Mapped Translation Buffer with Permission and Dirty Tracking

This block holds a small set of recent virtual-to-physical page translations for 4 KB pages. Each request carries a 32-bit virtual address and an access type. The virtual page number is the address with its low 12 bits removed. Its low bits pick exactly one entry, and its high bits must equal that entry's stored tag. The answer comes back one clock after the request. It is one of three results:

- a hit, with the physical address;
- a miss, so that an external walker can fetch the translation;
- a protection fault, when the entry matches but does not allow the access type.

The walker refills an entry through a fill port that takes a virtual page number, a physical page number and three permission bits. A flush input drops every translation at once. A permitted store marks its entry dirty. Each hit reports the entry's dirty state, so the surrounding logic can tell when a page needs write-back bookkeeping.

Top module: `tlb_dm`

## Requirements
- R1: After reset every entry is invalid, all response outputs are 0, and every lookup misses until an entry is filled.
- R2: The entry index is VA[15:12] and the tag is VA[31:16]. A lookup matches only if the indexed entry is valid and its stored tag equals the tag. A tag differing in any single bit, or a tag that belongs to another index, misses.
- R3: A request sampled on a clock edge is answered on the next edge. On that edge rsp_valid_o is 1 and exactly one of rsp_hit_o, rsp_miss_o and rsp_fault_o is 1. With no request, all four are 0, and so are rsp_pa_o and rsp_dirty_o.
- R4: On a hit, rsp_pa_o equals the entry's physical page number in bits [31:12] followed by VA[11:0] unchanged. On a miss or a fault, rsp_pa_o is 0.
- R5: Access codes are 0 = load, 1 = store, 2 = fetch. Permission bits are bit 0 = read, bit 1 = write, bit 2 = execute. A matching entry whose permission bit for the access is 0 gives rsp_fault_o instead of rsp_hit_o.
- R6: Access code 3 is never permitted. On a tag match it gives a fault, and otherwise it gives a miss.
- R7: A store hit sets the entry's dirty bit. On a hit, rsp_dirty_o shows the entry's dirty bit after the access. Loads, fetches, faults and misses leave the dirty bit unchanged, and rsp_dirty_o is 0 on a miss or a fault.
- R8: A fill writes the tag, the physical page number and the permissions, sets valid and clears dirty. Lookups from the next cycle on see the new contents. A lookup in the same cycle as the fill sees the old contents.
- R9: A flush clears every valid bit. A fill in the same cycle survives for its own entry. A lookup in the flush cycle still sees the entries as they were before the flush.
- R10: When a fill and a store hit target the same entry in the same cycle, the store is answered from the old contents and the entry ends with dirty 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request |
| req_va_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| fill_en_i | input | 1 | Write one entry |
| fill_vpn_i | input | 20 | Virtual page number of the fill |
| fill_ppn_i | input | 20 | Physical page number of the fill |
| fill_perm_i | input | 3 | Fill permissions: bit 0 read, bit 1 write, bit 2 execute |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Translation found and permitted |
| rsp_miss_o | output | 1 | No valid entry with a matching tag |
| rsp_fault_o | output | 1 | Entry matched but the access is not permitted |
| rsp_pa_o | output | 32 | Physical address on a hit, else 0 |
| rsp_dirty_o | output | 1 | Entry dirty bit after the access, on a hit |

## Verification
All 16 entries are filled with distinct tags and page numbers. Their permissions run through all eight combinations, so the sweep of four access types over every entry separates a permitted hit from a fault for each permission bit and for the reserved code. Single-bit tag flips at each of the 16 tag bit positions, and tags moved to a neighbouring index, separate a correct tag compare and index slice from a partial one. Varied page offsets separate a pass-through offset from a swapped or truncated one. Repeated loads after stores, a refill during a lookup, a flush during a fill and a fill during a store to the same entry separate the dirty-bit handling and the same-cycle priorities.

// File: rtl/tlb_dm_pkg.sv
`timescale 1ns/1ps
package tlb_dm_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_W   = 3;
  localparam int PERM_RD  = 0;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 2;
endpackage

// File: rtl/tlb_dm_store.sv
`timescale 1ns/1ps
module tlb_dm_store
  import tlb_dm_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 16,
  parameter int PPN_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [PERM_W-1:0] fill_perm_i,
  input  logic              dset_en_i,
  input  logic [IDX_W-1:0]  dset_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [PPN_W-1:0]  rd_ppn_o,
  output logic [PERM_W-1:0] rd_perm_o
);
  localparam int N_ENT = 1 << IDX_W;

  logic [N_ENT-1:0]  valid_vec;
  logic [N_ENT-1:0]  dirty_vec;
  logic [TAG_W-1:0]  tag_arr  [N_ENT];
  logic [PPN_W-1:0]  ppn_arr  [N_ENT];
  logic [PERM_W-1:0] perm_arr [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic              v_q, d_q;
    logic [TAG_W-1:0]  t_q;
    logic [PPN_W-1:0]  p_q;
    logic [PERM_W-1:0] pm_q;
    logic              fill_me, dset_me;

    assign fill_me = fill_en_i && (fill_idx_i == IDX_W'(g));
    assign dset_me = dset_en_i && (dset_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q  <= 1'b0;
        d_q  <= 1'b0;
        t_q  <= '0;
        p_q  <= '0;
        pm_q <= '0;
      end else if (fill_me) begin
        // fill outranks flush and dirty-set on its own entry
        v_q  <= 1'b1;
        d_q  <= 1'b0;
        t_q  <= fill_tag_i;
        p_q  <= fill_ppn_i;
        pm_q <= fill_perm_i;
      end else begin
        if (flush_i) v_q <= 1'b0;
        if (dset_me) d_q <= 1'b1;
      end
    end

    assign valid_vec[g] = v_q;
    assign dirty_vec[g] = d_q;
    assign tag_arr[g]   = t_q;
    assign ppn_arr[g]   = p_q;
    assign perm_arr[g]  = pm_q;
  end

  assign rd_valid_o = valid_vec[rd_idx_i];
  assign rd_dirty_o = dirty_vec[rd_idx_i];
  assign rd_tag_o   = tag_arr[rd_idx_i];
  assign rd_ppn_o   = ppn_arr[rd_idx_i];
  assign rd_perm_o  = perm_arr[rd_idx_i];

  // R8: filled entry is valid, clean and holds the written tag
  assert_fill_lands_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> valid_vec[$past(fill_idx_i)] && !dirty_vec[$past(fill_idx_i)]
                  && tag_arr[$past(fill_idx_i)] == $past(fill_tag_i));

  // R9: flush without a fill leaves nothing valid
  assert_flush_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !fill_en_i) |=> valid_vec == '0);

  // R7: a dirty-set not overridden by a fill sticks
  assert_dirty_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dset_en_i && !(fill_en_i && fill_idx_i == dset_idx_i)) |=> dirty_vec[$past(dset_idx_i)]);

  // R10: fill on the same entry as a dirty-set leaves it clean
  assert_fill_beats_dirty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dset_en_i && fill_en_i && fill_idx_i == dset_idx_i) |=> !dirty_vec[$past(dset_idx_i)]);
endmodule

// File: rtl/tlb_dm_match.sv
`timescale 1ns/1ps
module tlb_dm_match
  import tlb_dm_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 4,
  parameter int PPN_W = 20
) (
  input  logic                   req_valid_i,
  input  logic [VA_W-1:0]        req_va_i,
  input  logic [1:0]             req_acc_i,
  output logic [IDX_W-1:0]       rd_idx_o,
  input  logic                   rd_valid_i,
  input  logic                   rd_dirty_i,
  input  logic [VA_W-OFF_W-IDX_W-1:0] rd_tag_i,
  input  logic [PPN_W-1:0]       rd_ppn_i,
  input  logic [PERM_W-1:0]      rd_perm_i,
  output logic                   hit_o,
  output logic                   miss_o,
  output logic                   fault_o,
  output logic [PPN_W+OFF_W-1:0] pa_o,
  output logic                   dset_o,
  output logic                   dirty_o
);
  localparam int VPN_W = VA_W - OFF_W;

  logic [VPN_W-1:0] vpn;
  logic             tag_eq, allowed;
  acc_e             acc;

  assign vpn      = req_va_i[VA_W-1:OFF_W];
  assign rd_idx_o = vpn[IDX_W-1:0];
  assign acc      = acc_e'(req_acc_i);
  assign tag_eq   = rd_valid_i && (rd_tag_i == vpn[VPN_W-1:IDX_W]);

  always_comb begin
    unique case (acc)
      ACC_LOAD:  allowed = rd_perm_i[PERM_RD];
      ACC_STORE: allowed = rd_perm_i[PERM_WR];
      ACC_FETCH: allowed = rd_perm_i[PERM_EX];
      default:   allowed = 1'b0;
    endcase
  end

  assign hit_o   = req_valid_i && tag_eq && allowed;
  assign fault_o = req_valid_i && tag_eq && !allowed;
  assign miss_o  = req_valid_i && !tag_eq;
  assign pa_o    = {rd_ppn_i, req_va_i[OFF_W-1:0]};
  assign dset_o  = hit_o && (acc == ACC_STORE);
  assign dirty_o = rd_dirty_i || dset_o;
endmodule

// File: rtl/tlb_dm_resp.sv
`timescale 1ns/1ps
module tlb_dm_resp #(
  parameter int PA_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            hit_i,
  input  logic            miss_i,
  input  logic            fault_i,
  input  logic [PA_W-1:0] pa_i,
  input  logic            dirty_i,
  output logic            rsp_valid_o,
  output logic            rsp_hit_o,
  output logic            rsp_miss_o,
  output logic            rsp_fault_o,
  output logic [PA_W-1:0] rsp_pa_o,
  output logic            rsp_dirty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_pa_o    <= '0;
      rsp_dirty_o <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= hit_i;
      rsp_miss_o  <= miss_i;
      rsp_fault_o <= fault_i;
      rsp_pa_o    <= hit_i ? pa_i : '0;
      rsp_dirty_o <= hit_i && dirty_i;
    end
  end
endmodule

// File: rtl/tlb_dm.sv
`timescale 1ns/1ps
module tlb_dm
  import tlb_dm_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 4,
  parameter int PPN_W = 20
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   req_valid_i,
  input  logic [VA_W-1:0]        req_va_i,
  input  logic [1:0]             req_acc_i,
  input  logic                   fill_en_i,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]       fill_ppn_i,
  input  logic [2:0]             fill_perm_i,
  output logic                   rsp_valid_o,
  output logic                   rsp_hit_o,
  output logic                   rsp_miss_o,
  output logic                   rsp_fault_o,
  output logic [PPN_W+OFF_W-1:0] rsp_pa_o,
  output logic                   rsp_dirty_o
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int PA_W  = PPN_W + OFF_W;

  logic [IDX_W-1:0]  rd_idx;
  logic              rd_valid, rd_dirty;
  logic [TAG_W-1:0]  rd_tag;
  logic [PPN_W-1:0]  rd_ppn;
  logic [PERM_W-1:0] rd_perm;
  logic              m_hit, m_miss, m_fault, m_dset, m_dirty;
  logic [PA_W-1:0]   m_pa;

  tlb_dm_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .fill_en_i   (fill_en_i),
    .fill_idx_i  (fill_vpn_i[IDX_W-1:0]),
    .fill_tag_i  (fill_vpn_i[VPN_W-1:IDX_W]),
    .fill_ppn_i  (fill_ppn_i),
    .fill_perm_i (fill_perm_i),
    .dset_en_i   (m_dset),
    .dset_idx_i  (rd_idx),
    .rd_idx_i    (rd_idx),
    .rd_valid_o  (rd_valid),
    .rd_dirty_o  (rd_dirty),
    .rd_tag_o    (rd_tag),
    .rd_ppn_o    (rd_ppn),
    .rd_perm_o   (rd_perm)
  );

  tlb_dm_match #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PPN_W(PPN_W)) u_match (
    .req_valid_i (req_valid_i),
    .req_va_i    (req_va_i),
    .req_acc_i   (req_acc_i),
    .rd_idx_o    (rd_idx),
    .rd_valid_i  (rd_valid),
    .rd_dirty_i  (rd_dirty),
    .rd_tag_i    (rd_tag),
    .rd_ppn_i    (rd_ppn),
    .rd_perm_i   (rd_perm),
    .hit_o       (m_hit),
    .miss_o      (m_miss),
    .fault_o     (m_fault),
    .pa_o        (m_pa),
    .dset_o      (m_dset),
    .dirty_o     (m_dirty)
  );

  tlb_dm_resp #(.PA_W(PA_W)) u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .hit_i       (m_hit),
    .miss_i      (m_miss),
    .fault_i     (m_fault),
    .pa_i        (m_pa),
    .dirty_i     (m_dirty),
    .rsp_valid_o (rsp_valid_o),
    .rsp_hit_o   (rsp_hit_o),
    .rsp_miss_o  (rsp_miss_o),
    .rsp_fault_o (rsp_fault_o),
    .rsp_pa_o    (rsp_pa_o),
    .rsp_dirty_o (rsp_dirty_o)
  );

  // R3: one-cycle response, exactly one outcome
  assert_rsp_follows_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(req_valid_i));
  assert_one_outcome_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_hit_o, rsp_miss_o, rsp_fault_o}) == 1);

  // R4: page offset passes through untranslated
  assert_offset_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_pa_o[OFF_W-1:0] == $past(req_va_i[OFF_W-1:0]));

  // R6: reserved access code never hits
  assert_rsvd_no_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_acc_i == 2'd3) |=> !rsp_hit_o);

  // R7: faults and misses report clean
  assert_nohit_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_hit_o |-> !rsp_dirty_o);
endmodule

// File: tb/tlb_dm_bench.sv
`timescale 1ns/1ps
module tlb_dm_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_va_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        fill_en_i = 1'b0;
  logic [19:0] fill_vpn_i = '0;
  logic [19:0] fill_ppn_i = '0;
  logic [2:0]  fill_perm_i = '0;
  logic        rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o, rsp_dirty_o;
  logic [31:0] rsp_pa_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  logic        m_valid [16];
  logic        m_dirty [16];
  logic [15:0] m_tag   [16];
  logic [19:0] m_ppn   [16];
  logic [2:0]  m_perm  [16];

  always #2 clk = ~clk;

  tlb_dm u_tlb_dm (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .req_valid_i(req_valid_i), .req_va_i(req_va_i), .req_acc_i(req_acc_i),
    .fill_en_i(fill_en_i), .fill_vpn_i(fill_vpn_i), .fill_ppn_i(fill_ppn_i),
    .fill_perm_i(fill_perm_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_miss_o(rsp_miss_o),
    .rsp_fault_o(rsp_fault_o), .rsp_pa_o(rsp_pa_o), .rsp_dirty_o(rsp_dirty_o)
  );

  function automatic logic [15:0] tag_of(int i);
    return 16'hA000 ^ 16'(i * 16'h0111);
  endfunction
  function automatic logic [19:0] ppn_of(int i);
    return 20'h12345 + 20'(i * 20'h01011);
  endfunction
  function automatic logic [31:0] va_of(logic [15:0] tag, int idx, logic [11:0] off);
    return {tag, 4'(idx), off};
  endfunction

  task automatic cycle(input bit rv, input logic [31:0] va, input logic [1:0] acc,
                       input bit fe, input logic [19:0] fvpn, input logic [19:0] fppn,
                       input logic [2:0] fperm, input bit fl, input string rq);
    int idx;
    bit tag_eq, ok, e_hit, e_miss, e_fault, e_dirty;
    logic [31:0] e_pa;
    @(negedge clk);
    req_valid_i = rv; req_va_i = va; req_acc_i = acc;
    fill_en_i = fe; fill_vpn_i = fvpn; fill_ppn_i = fppn; fill_perm_i = fperm;
    flush_i = fl;
    idx    = int'(va[15:12]);
    tag_eq = m_valid[idx] && (m_tag[idx] == va[31:16]);
    case (acc)
      2'd0:    ok = m_perm[idx][0];
      2'd1:    ok = m_perm[idx][1];
      2'd2:    ok = m_perm[idx][2];
      default: ok = 1'b0;
    endcase
    e_hit   = rv && tag_eq && ok;
    e_fault = rv && tag_eq && !ok;
    e_miss  = rv && !tag_eq;
    e_pa    = e_hit ? {m_ppn[idx], va[11:0]} : 32'h0;
    e_dirty = e_hit && (m_dirty[idx] || acc == 2'd1);
    @(posedge clk);
    #1;
    n_vec++;
    if (rsp_valid_o !== rv || rsp_hit_o !== e_hit || rsp_miss_o !== e_miss ||
        rsp_fault_o !== e_fault || rsp_pa_o !== e_pa || rsp_dirty_o !== e_dirty) begin
      n_bad++;
      $display("FAIL %s: va=%h acc=%0d got v%0b h%0b m%0b f%0b pa=%h d%0b exp v%0b h%0b m%0b f%0b pa=%h d%0b",
               rq, va, acc, rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o, rsp_pa_o, rsp_dirty_o,
               rv, e_hit, e_miss, e_fault, e_pa, e_dirty);
    end
    if (e_hit && acc == 2'd1) m_dirty[idx] = 1'b1;
    if (fl) for (int k = 0; k < 16; k++) m_valid[k] = 1'b0;
    if (fe) begin
      m_valid[fvpn[3:0]] = 1'b1;
      m_dirty[fvpn[3:0]] = 1'b0;
      m_tag[fvpn[3:0]]   = fvpn[19:4];
      m_ppn[fvpn[3:0]]   = fppn;
      m_perm[fvpn[3:0]]  = fperm;
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] acc, input string rq);
    cycle(1'b1, va, acc, 1'b0, '0, '0, '0, 1'b0, rq);
  endtask

  task automatic fill(input int i, input logic [15:0] tag, input logic [19:0] ppn,
                      input logic [2:0] perm, input string rq);
    cycle(1'b0, '0, 2'd0, 1'b1, {tag, 4'(i)}, ppn, perm, 1'b0, rq);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin
      m_valid[k] = 0; m_dirty[k] = 0; m_tag[k] = '0; m_ppn[k] = '0; m_perm[k] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    n_vec++;  // R1 reset outputs
    if ({rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o, rsp_dirty_o} !== 5'b0 || rsp_pa_o !== 32'h0) begin
      n_bad++;
      $display("FAIL R1: reset outputs got %b pa=%h exp 0", {rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o, rsp_dirty_o}, rsp_pa_o);
    end
    @(negedge clk) rst_ni = 1'b1;

    for (int i = 0; i < 16; i++) look(va_of(tag_of(i), i, 12'h5A5), 2'd0, "R1");
    for (int i = 0; i < 16; i++) fill(i, tag_of(i), ppn_of(i), 3'(i), "R8");
    cycle(1'b0, '0, 2'd0, 1'b0, '0, '0, '0, 1'b0, "R3");

    for (int i = 0; i < 16; i++) look(va_of(tag_of(i), i, 12'(i * 12'h2AB + 1)), 2'd0, "R4");
    for (int i = 0; i < 16; i++)
      for (int a = 0; a < 4; a++)
        look(va_of(tag_of(i), i, 12'(a * 12'h155 + i)), 2'(a), (a == 3) ? "R6" : "R5");
    for (int i = 0; i < 16; i++) begin
      look(va_of(tag_of(i) ^ 16'(1 << i), i, 12'hFFF), 2'd0, "R2");
      look(va_of(tag_of(i), (i + 1) % 16, 12'h000), 2'd0, "R2");
    end
    for (int i = 0; i < 16; i++) look(va_of(tag_of(i), i, 12'h321), 2'd0, "R7");
    for (int i = 0; i < 16; i++) look(va_of(tag_of(i), i, 12'h321), 2'd2, "R7");

    // refill idx 5 while looking it up
    cycle(1'b1, va_of(tag_of(5), 5, 12'h0F0), 2'd0, 1'b1, {16'h5555, 4'd5}, 20'hBEEF1, 3'b111, 1'b0, "R8");
    look(va_of(tag_of(5), 5, 12'h0F0), 2'd0, "R8");
    look(va_of(16'h5555, 5, 12'h0F0), 2'd0, "R8");
    look(va_of(16'h5555, 5, 12'h00F), 2'd1, "R7");
    look(va_of(16'h5555, 5, 12'h00F), 2'd0, "R7");

    // store and fill on idx 6 in one cycle
    cycle(1'b1, va_of(tag_of(6), 6, 12'hABC), 2'd1, 1'b1, {tag_of(6), 4'd6}, 20'h0C0DE, 3'b111, 1'b0, "R10");
    look(va_of(tag_of(6), 6, 12'hABC), 2'd0, "R10");

    // flush with a fill and a lookup in the same cycle
    cycle(1'b1, va_of(tag_of(3), 3, 12'h777), 2'd0, 1'b1, {16'h9999, 4'd9}, 20'hF0F0F, 3'b001, 1'b1, "R9");
    for (int i = 0; i < 16; i++) look(va_of(tag_of(i), i, 12'h444), 2'd0, "R9");
    look(va_of(16'h9999, 9, 12'h444), 2'd0, "R9");
    cycle(1'b0, '0, 2'd0, 1'b0, '0, '0, '0, 1'b0, "R3");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run got stuck, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule